// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It takes the memory from power-up to a usable state. After reset it holds the command pins at NOP for a power-up delay. The delay is given in microseconds and converted to clock cycles from a clock-frequency parameter. It then closes every bank with one precharge and runs two auto refreshes. Last, it loads the mode register with a word built from parameters: burst length code, burst type, CAS latency and write-burst mode.

Each command lasts one cycle and is followed by a wait of NOPs. The wait length for each command is a parameter. Once the wait after the mode load has elapsed, the done flag rises and stays high. The command pins then stay at NOP, so a later controller can take over. A reset at any point restarts the whole sequence.

Top module: `sdram_boot_seq`

## Requirements
- R1: From reset until cycle P-1 (P = ceil(CLK_HZ/1000 * POWERUP_US / 1000) cycles after reset is released, counted from 0), the pins {cs_n,ras_n,cas_n,we_n} show NOP = 4'b0111, with address and bank at zero and done low.
- R2: In cycle P exactly one precharge-all is issued, encoded 4'b0010, with address bit 10 high and every other address and bank bit low.
- R3: The precharge is followed by exactly WAIT_PRE NOP cycles.
- R4: Two auto refreshes, encoded 4'b0001, are issued after that wait. Each is followed by exactly WAIT_REF NOP cycles, and no refresh comes before the precharge.
- R5: After the second refresh wait, one mode load, encoded 4'b0000, is issued. The bank is zero and the address carries the mode word: bits 2:0 the burst length code, bit 3 the burst type (1 = interleaved), bits 6:4 the CAS latency code, bits 8:7 equal to 00, bit 9 the write-burst mode (1 = single write), and all higher bits zero.
- R6: The CAS latency code is 3'b010 for latency 2 and 3'b011 for latency 3. Any other latency, a wait below one cycle, or an address narrower than 11 bits is rejected at elaboration.
- R7: After the mode load come exactly WAIT_MODE NOP cycles. The done flag rises in the next cycle and then stays high, with the pins held at NOP, until reset.
- R8: Asserting the active-low reset at any point forces NOP and done low at once. Releasing it restarts the full sequence from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Address pins (precharge-all flag or mode word) |
| sd_ba | output | BANK_W | Bank select, zero throughout |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Two events can fall in the same cycle here. One is the expiry of a step's wait count. The other is an asynchronous reset, which must win over the step advance that the expiry would cause. The bench drives reset in the middle of the refresh waits of one configuration, while the other configuration has already finished. It then checks that both fall back to NOP with done low, and that each one replays every cycle of the sequence from zero. A second case is the last wait cycle before done coinciding with the counter restart. Each cycle's command is compared against a timeline computed arithmetically from the wait parameters. This shows that done rises exactly one cycle after the wait ends and never overlaps a command.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR   = 4'd0,
    ST_PRE   = 4'd1,
    ST_WPRE  = 4'd2,
    ST_REF1  = 4'd3,
    ST_WREF1 = 4'd4,
    ST_REF2  = 4'd5,
    ST_WREF2 = 4'd6,
    ST_LMR   = 4'd7,
    ST_WLMR  = 4'd8,
    ST_DONE  = 4'd9
  } boot_step_e;

  // cycles for a delay in microseconds, rounded up
  function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
    longint unsigned prod;
    prod = (longint'(hz) / 1000) * longint'(us);
    return int'((prod + 999) / 1000);
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [2:0] cas_code(input int unsigned lat);
    return (lat == 3) ? 3'b011 : 3'b010;
  endfunction

  // mode word: [9] write mode, [8:7] op mode 00, [6:4] CAS code, [3] type, [2:0] length
  function automatic logic [9:0] mode_word(input logic [2:0] bl, input logic il,
                                           input logic [2:0] cl, input logic wb);
    return {wb, 2'b00, cl, il, bl};
  endfunction

  function automatic boot_step_e next_step(input boot_step_e s);
    boot_step_e n;
    case (s)
      ST_PWR:   n = ST_PRE;
      ST_PRE:   n = ST_WPRE;
      ST_WPRE:  n = ST_REF1;
      ST_REF1:  n = ST_WREF1;
      ST_WREF1: n = ST_REF2;
      ST_REF2:  n = ST_WREF2;
      ST_WREF2: n = ST_LMR;
      ST_LMR:   n = ST_WLMR;
      default:  n = ST_DONE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          hold,
  input  logic [CW-1:0] len,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!hold)   cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == len - 1'b1);

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (cnt_q < len)); // R3

endmodule

// File: rtl/boot_step_fsm.sv
module boot_step_fsm
  import sdram_boot_pkg::*;
#(
  parameter int CW        = 8,
  parameter int PWR_CYC   = 100,
  parameter int WAIT_PRE  = 3,
  parameter int WAIT_REF  = 10,
  parameter int WAIT_MODE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          timer_last,
  output boot_step_e    step,
  output logic [CW-1:0] step_len,
  output logic          advance,
  output logic          parked
);

  boot_step_e step_q;

  always_comb begin
    case (step_q)
      ST_PWR:            step_len = CW'(PWR_CYC);
      ST_WPRE:           step_len = CW'(WAIT_PRE);
      ST_WREF1, ST_WREF2: step_len = CW'(WAIT_REF);
      ST_WLMR:           step_len = CW'(WAIT_MODE);
      default:           step_len = CW'(1);
    endcase
  end

  assign parked  = (step_q == ST_DONE);
  assign advance = timer_last && !parked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= ST_PWR;
    else if (advance) step_q <= next_step(step_q);
  end

  assign step = step_q;

  AST_DONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    parked |=> parked); // R7
  AST_SINGLE_CMD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q inside {ST_PRE, ST_REF1, ST_REF2, ST_LMR}) |-> timer_last); // R3

endmodule

// File: rtl/boot_pin_drive.sv
module boot_pin_drive
  import sdram_boot_pkg::*;
#(
  parameter int          ROW_W  = 12,
  parameter int          BANK_W = 2,
  parameter logic [9:0]  MWORD  = 10'h023
) (
  input  boot_step_e        step,
  output logic [3:0]        cmd,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba
);

  localparam logic [ROW_W-1:0] PRE_ALL  = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MODE_PIN = {{(ROW_W-10){1'b0}}, MWORD};

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    case (step)
      ST_PRE: begin
        cmd  = CMD_PRE;
        addr = PRE_ALL;
      end
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_LMR: begin
        cmd  = CMD_LMR;
        addr = MODE_PIN;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int          CLK_HZ      = 50_000_000,
  parameter int          POWERUP_US  = 100,
  parameter int          WAIT_PRE    = 3,
  parameter int          WAIT_REF    = 10,
  parameter int          WAIT_MODE   = 2,
  parameter int          ROW_W       = 12,
  parameter int          BANK_W      = 2,
  parameter logic [2:0]  BURST_CODE  = 3'b011,
  parameter bit          BURST_ILV   = 1'b0,
  parameter int          CAS_LAT     = 2,
  parameter bit          SINGLE_WR   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_done
);

  localparam int          PWR_CYC = us_to_cycles(CLK_HZ, POWERUP_US);
  localparam int          MAXLEN  = max_of4(PWR_CYC, WAIT_PRE, WAIT_REF, WAIT_MODE);
  localparam int          CW      = $clog2(MAXLEN + 1) + 1;
  localparam logic [9:0]  MWORD   = mode_word(BURST_CODE, BURST_ILV, cas_code(CAS_LAT), SINGLE_WR);

  generate
    if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cas
      $error("CAS latency must be 2 or 3");
    end
    if (ROW_W < 11) begin : g_bad_row
      $error("address width must be at least 11");
    end
    if (WAIT_PRE < 1 || WAIT_REF < 1 || WAIT_MODE < 1 || PWR_CYC < 1) begin : g_bad_wait
      $error("every wait must last at least one cycle");
    end
  endgenerate

  boot_step_e          step;
  logic [CW-1:0]       step_len;
  logic                advance;
  logic                parked;
  logic                timer_last;
  logic [3:0]          cmd;

  boot_wait_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (advance),
    .hold    (parked),
    .len     (step_len),
    .last    (timer_last)
  );

  boot_step_fsm #(
    .CW(CW), .PWR_CYC(PWR_CYC), .WAIT_PRE(WAIT_PRE),
    .WAIT_REF(WAIT_REF), .WAIT_MODE(WAIT_MODE)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_last (timer_last),
    .step       (step),
    .step_len   (step_len),
    .advance    (advance),
    .parked     (parked)
  );

  boot_pin_drive #(.ROW_W(ROW_W), .BANK_W(BANK_W), .MWORD(MWORD)) u_pins (
    .step (step),
    .cmd  (cmd),
    .addr (sd_addr),
    .ba   (sd_ba)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign init_done = parked;

  // pin-level events, brought out for the checks below
  logic ev_pre, ev_ref, ev_lmr, ev_any;
  assign ev_pre = (cmd == CMD_PRE);
  assign ev_ref = (cmd == CMD_REF);
  assign ev_lmr = (cmd == CMD_LMR);
  assign ev_any = (cmd != CMD_NOP);

  logic [CW-1:0] since_rst;
  logic          pre_seen;
  logic [1:0]    ref_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      pre_seen  <= 1'b0;
      ref_seen  <= '0;
    end else begin
      if (since_rst < CW'(PWR_CYC)) since_rst <= since_rst + 1'b1;
      if (ev_pre) pre_seen <= 1'b1;
      if (ev_ref && ref_seen != 2'd3) ref_seen <= ref_seen + 1'b1;
    end
  end

  AST_POWERUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |-> (since_rst >= CW'(PWR_CYC))); // R1
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |-> (sd_addr[10] && sd_ba == '0)); // R2
  AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> !ev_any); // R3
  AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ref |-> (pre_seen && ref_seen < 2'd2)); // R4
  AST_LMR_AFTER_TWO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lmr |-> (ref_seen == 2'd2)); // R5
  AST_LMR_HIGH_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lmr |-> (sd_ba == '0 && sd_addr[ROW_W-1:10] == '0 && sd_addr[8:7] == 2'b00)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !ev_any); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R7

endmodule

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;

  localparam int PP [2]  = '{20, 14};
  localparam int TP [2]  = '{3, 1};
  localparam int TR [2]  = '{10, 2};
  localparam int TM [2]  = '{2, 1};
  localparam int BL [2]  = '{3, 0};
  localparam int IL [2]  = '{0, 1};
  localparam int CL [2]  = '{2, 3};
  localparam int WB [2]  = '{0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cs_n [2], ras_n [2], cas_n [2], we_n [2], done [2];
  logic [11:0] addr [2];
  logic [1:0]  ba [2];

  sdram_boot_seq #(
    .CLK_HZ(1_000_000), .POWERUP_US(20), .WAIT_PRE(3), .WAIT_REF(10), .WAIT_MODE(2),
    .ROW_W(12), .BANK_W(2), .BURST_CODE(3'b011), .BURST_ILV(1'b0), .CAS_LAT(2), .SINGLE_WR(1'b0)
  ) i_sdram_boot_seq (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(cs_n[0]), .sd_ras_n(ras_n[0]), .sd_cas_n(cas_n[0]),
    .sd_we_n(we_n[0]), .sd_addr(addr[0]), .sd_ba(ba[0]), .init_done(done[0])
  );

  sdram_boot_seq #(
    .CLK_HZ(2_000_000), .POWERUP_US(7), .WAIT_PRE(1), .WAIT_REF(2), .WAIT_MODE(1),
    .ROW_W(12), .BANK_W(2), .BURST_CODE(3'b000), .BURST_ILV(1'b1), .CAS_LAT(3), .SINGLE_WR(1'b1)
  ) i_sdram_boot_seq_b (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(cs_n[1]), .sd_ras_n(ras_n[1]), .sd_cas_n(cas_n[1]),
    .sd_we_n(we_n[1]), .sd_addr(addr[1]), .sd_ba(ba[1]), .init_done(done[1])
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int inst, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s inst%0d %s: actual=%0h expected=%0h", req, inst, what, act, exp);
    end
  endtask

  // timeline boundaries for instance i
  function automatic int t_ref1(input int i); return PP[i] + TP[i] + 1; endfunction
  function automatic int t_ref2(input int i); return t_ref1(i) + TR[i] + 1; endfunction
  function automatic int t_lmr(input int i);  return t_ref2(i) + TR[i] + 1; endfunction
  function automatic int t_done(input int i); return t_lmr(i) + TM[i] + 1; endfunction

  function automatic int exp_cmd(input int i, input int k);
    if (k == PP[i]) return 4'b0010;
    if (k == t_ref1(i) || k == t_ref2(i)) return 4'b0001;
    if (k == t_lmr(i)) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic int exp_addr(input int i, input int k);
    if (k == PP[i]) return 1 << 10;
    if (k == t_lmr(i)) return BL[i] + IL[i] * 8 + CL[i] * 16 + WB[i] * 512;
    return 0;
  endfunction

  function automatic string req_of(input int i, input int k);
    if (k < PP[i]) return "R1";
    if (k == PP[i]) return "R2";
    if (k < t_ref1(i)) return "R3";
    if (k < t_lmr(i)) return "R4";
    if (k == t_lmr(i)) return "R5";
    return "R7";
  endfunction

  task automatic check_cycle(input int k);
    for (int i = 0; i < 2; i++) begin
      string r;
      r = req_of(i, k);
      check(r, i, $sformatf("cmd k=%0d", k), {cs_n[i], ras_n[i], cas_n[i], we_n[i]}, exp_cmd(i, k));
      check(r, i, $sformatf("addr k=%0d", k), addr[i], exp_addr(i, k));
      check(r, i, $sformatf("bank k=%0d", k), ba[i], 0);
      check("R7", i, $sformatf("done k=%0d", k), done[i], (k >= t_done(i)) ? 1 : 0);
      if (k == t_lmr(i)) // R6 CAS code in bits 6:4
        check("R6", i, "cas code", addr[i][6:4], CL[i]);
    end
  endtask

  task automatic check_reset_state(input string req);
    for (int i = 0; i < 2; i++) begin
      check(req, i, "cmd in reset", {cs_n[i], ras_n[i], cas_n[i], we_n[i]}, 4'b0111);
      check(req, i, "addr in reset", addr[i], 0);
      check(req, i, "done in reset", done[i], 0);
    end
  endtask

  task automatic run_from_release(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      check_cycle(k);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("R8");
    repeat (2) @(negedge clk);
    check_reset_state("R8");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    run_from_release(80);          // full sequence, done held for many cycles
    pulse_reset();
    run_from_release(30);          // instance 0 interrupted in refresh wait, instance 1 finished
    pulse_reset();
    run_from_release(80);          // full replay after mid-sequence reset (R8)
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule